// File: doc/BRIEF.md
# Trellis Redundancy Bit Encoder

This block adds the ninth, redundancy bit to each symbol period of a five-level (PAM-5) transmit path. Once per symbol, marked by a one-cycle symbol strobe, it takes the two most significant scrambled data bits and advances a three-bit feedback shift-register encoder. It drives the extra bit from the encoder state. The redundancy bit joins the eight scrambled data bits to form the nine-bit word that the symbol mapper consumes.

The encoder also exports the two low state bits, which hold the state from the previous symbol period. The upstream data scrambler uses them. A transmit-enable input gates the encoder. While transmit-enable is low, the redundancy bit is forced low, and every symbol strobe returns the state to zero. Data then starts from a known state when transmission resumes. A synchronous reset clears the state.

Top module: `trellis_enc`

## Requirements
- R1: A clock edge with `rst` high clears all three state bits, whatever the other inputs are, so that `cs_dly` reads 0 and `red_bit` reads 0 after it.
- R2: On a clock edge with `sym_en` and `tx_en` high and `rst` low, the state updates from its previous value s as follows: new bit 0 = s[1], new bit 1 = `sd_pair[0]` ^ s[2], new bit 2 = `sd_pair[1]` ^ s[0]. Here `sd_pair[1]` is the more significant data bit (bit 7 of the data word) and `sd_pair[0]` is bit 6.
- R3: While `tx_en` is high, `red_bit` equals state bit 0 in the same cycle. It is a combinational output with no added register.
- R4: While `tx_en` is low, `red_bit` is 0 in every cycle.
- R5: On a clock edge with `sym_en` high, `tx_en` low and `rst` low, the state becomes 0, whatever `sd_pair` is.
- R6: On a clock edge with `sym_en` low and `rst` low, the state keeps its value. `sd_pair` and `tx_en` have no effect on it.
- R7: `cs_dly` shows state bits 1 and 0, with state bit 0 at `cs_dly[0]` and state bit 1 at `cs_dly[1]`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_en | input | 1 | Symbol strobe; the encoder advances once on each edge where it is high |
| tx_en | input | 1 | Transmit enable; low forces the redundancy bit low and clears the state on strobes |
| sd_pair | input | 2 | Scrambled data bits 7 (bit 1) and 6 (bit 0) of the current symbol |
| red_bit | output | 1 | Redundancy bit, data bit 8 of the symbol word |
| cs_dly | output | 2 | State bits 1:0 from the previous symbol period, for the data scrambler |

## Verification
State bit 2 never appears at the ports directly, so a fault in its update can hide. It becomes visible only one strobe later, when it is folded into state bit 1 and shows on `cs_dly[1]`. The stimulus therefore runs long strobe sequences. Some of these hold `sd_pair[0]` at 0, so that the next `cs_dly[1]` reads state bit 2 with nothing folded into it. Other sequences walk every `sd_pair` value from a nonzero state. A second case that is hard to reach is a dropped transmit-enable. It only shows up as a cleared state if a strobe arrives while transmit-enable is low, and not if transmit-enable comes back first. The bench therefore holds transmit-enable low across both strobed and unstrobed cycles before it raises it again.

// File: rtl/trellis_pkg.sv
package trellis_pkg;
   localparam int unsigned ENC_STATE_W = 3;
   localparam int unsigned ENC_DATA_W  = 2;

   // State bit that feeds each state bit on a symbol step
   function automatic int unsigned tap_src(input int unsigned bitpos);
      case (bitpos)
         0:       tap_src = 1;
         1:       tap_src = 2;
         default: tap_src = 0;
      endcase
   endfunction

   // Data bit folded into each state bit; -1 when none is used
   function automatic int data_src(input int unsigned bitpos);
      case (bitpos)
         1:       data_src = 0;
         2:       data_src = 1;
         default: data_src = -1;
      endcase
   endfunction
endpackage

// File: rtl/trellis_next.sv
module trellis_next
   import trellis_pkg::*;
#(
   parameter int unsigned STATE_W = ENC_STATE_W,
   parameter int unsigned DATA_W  = ENC_DATA_W
) (
   input  logic [STATE_W-1:0] st,
   input  logic [DATA_W-1:0]  din,
   input  logic               active,
   output logic [STATE_W-1:0] nxt
);
   logic [STATE_W-1:0] stepped;

   for (genvar i = 0; i < STATE_W; i++) begin : g_bit
      if (data_src(i) < 0) begin : g_shift
         assign stepped[i] = st[tap_src(i)];
      end else begin : g_fold
         assign stepped[i] = st[tap_src(i)] ^ din[data_src(i)];
      end
   end

   assign nxt = active ? stepped : '0;
endmodule

// File: rtl/trellis_state_reg.sv
module trellis_state_reg #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (load) begin
         q <= d;
      end
   end
endmodule

// File: rtl/trellis_out.sv
module trellis_out #(
   parameter int unsigned LO_W = 2
) (
   input  logic [LO_W-1:0] st_lo,
   input  logic            active,
   output logic            red,
   output logic [LO_W-1:0] dly
);
   assign red = active & st_lo[0];
   assign dly = st_lo;
endmodule

// File: rtl/trellis_enc.sv
module trellis_enc
   import trellis_pkg::*;
#(
   parameter int unsigned DATA_W  = ENC_DATA_W,
   parameter int unsigned STATE_W = ENC_STATE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sym_en,
   input  logic              tx_en,
   input  logic [DATA_W-1:0] sd_pair,
   output logic              red_bit,
   output logic [STATE_W-2:0] cs_dly
);
   localparam int unsigned DLY_W = STATE_W - 1;

   if (DATA_W != ENC_DATA_W) begin : g_bad_data
      $error("trellis_enc: DATA_W must be %0d", ENC_DATA_W);
   end
   if (STATE_W != ENC_STATE_W) begin : g_bad_state
      $error("trellis_enc: STATE_W must be %0d", ENC_STATE_W);
   end

   logic [STATE_W-1:0] st_q;
   logic [STATE_W-1:0] st_d;

   trellis_next #(.STATE_W(STATE_W), .DATA_W(DATA_W)) u_next (
      .st     (st_q),
      .din    (sd_pair),
      .active (tx_en),
      .nxt    (st_d)
   );

   trellis_state_reg #(.W(STATE_W)) u_reg (
      .clk  (clk),
      .rst  (rst),
      .load (sym_en),
      .d    (st_d),
      .q    (st_q)
   );

   trellis_out #(.LO_W(DLY_W)) u_out (
      .st_lo  (st_q[DLY_W-1:0]),
      .active (tx_en),
      .red    (red_bit),
      .dly    (cs_dly)
   );
endmodule

// File: rtl/trellis_enc_chk.sv
module trellis_enc_chk (
   input logic       clk,
   input logic       rst,
   input logic       sym_en,
   input logic       tx_en,
   input logic [1:0] sd_pair,
   input logic       red_bit,
   input logic [1:0] cs_dly,
   input logic [2:0] st_q
);
   // R1
   a_r1_reset_clears: assert property (@(posedge clk)
      rst |=> (st_q == 3'b000 && cs_dly == 2'b00 && !red_bit));

   // R2
   a_r2_step: assert property (@(posedge clk) disable iff (rst)
      (sym_en && tx_en) |=>
         (st_q[0] == $past(st_q[1]) &&
          st_q[1] == ($past(sd_pair[0]) ^ $past(st_q[2])) &&
          st_q[2] == ($past(sd_pair[1]) ^ $past(st_q[0]))));

   // R3
   a_r3_red_follows: assert property (@(posedge clk) disable iff (rst)
      tx_en |-> (red_bit == st_q[0]));

   // R4
   a_r4_red_low_idle: assert property (@(posedge clk) disable iff (rst)
      !tx_en |-> !red_bit);

   // R5
   a_r5_idle_clears: assert property (@(posedge clk) disable iff (rst)
      (sym_en && !tx_en) |=> (st_q == 3'b000));

   // R6
   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      !sym_en |=> $stable(st_q));

   // R7
   a_r7_dly_view: assert property (@(posedge clk) disable iff (rst)
      cs_dly == st_q[1:0]);
endmodule

bind trellis_enc trellis_enc_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .sym_en  (sym_en),
   .tx_en   (tx_en),
   .sd_pair (sd_pair),
   .red_bit (red_bit),
   .cs_dly  (cs_dly),
   .st_q    (st_q)
);

// File: tb/trellis_enc_bench.sv
module trellis_enc_bench;
   localparam int CLK_P = 8;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sym_en = 1'b0;
   logic       tx_en = 1'b0;
   logic [1:0] sd_pair = 2'b00;
   logic       red_bit;
   logic [1:0] cs_dly;

   int checks = 0;
   int errors = 0;
   logic [2:0] m_st = 3'b000;

   always #(CLK_P/2) clk = ~clk;

   trellis_enc u_trellis_enc (
      .clk     (clk),
      .rst     (rst),
      .sym_en  (sym_en),
      .tx_en   (tx_en),
      .sd_pair (sd_pair),
      .red_bit (red_bit),
      .cs_dly  (cs_dly)
   );

   task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   // Drive inputs for one cycle, check outputs before the edge, update the model at the edge
   task automatic step(input string req, input logic s, input logic t, input logic [1:0] d);
      @(negedge clk);
      sym_en  = s;
      tx_en   = t;
      sd_pair = d;
      #1;
      chk({req, " cs_dly R7"}, {1'b0, cs_dly}, {1'b0, m_st[1:0]});
      chk({req, t ? " red_bit R3" : " red_bit R4"}, {2'b00, red_bit}, {2'b00, t & m_st[0]});
      @(posedge clk);
      if (rst) m_st = 3'b000;
      else if (s) m_st = t ? {d[1] ^ m_st[0], d[0] ^ m_st[2], m_st[1]} : 3'b000;
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1; sym_en = 1'b1; tx_en = 1'b1; sd_pair = 2'b11;
      @(posedge clk);
      m_st = 3'b000;
      @(negedge clk);
      rst = 1'b0; sym_en = 1'b0;
      #1;
      chk("R1 reset cs_dly", {1'b0, cs_dly}, 3'b000);
      chk("R1 reset red_bit", {2'b00, red_bit}, 3'b000);
   endtask

   task automatic t_encode_walk();
      for (int i = 0; i < 24; i++) begin
         step("R2 walk", 1'b1, 1'b1, 2'((i * 3 + 1) ^ (i >> 2)));
      end
      // sd_pair[0]=0 exposes old state bit 2 on the next cs_dly[1]
      for (int i = 0; i < 8; i++) begin
         step("R2 bit2 reveal", 1'b1, 1'b1, {i[0], 1'b0});
      end
   endtask

   task automatic t_hold();
      step("R2 prime", 1'b1, 1'b1, 2'b11);
      step("R2 prime", 1'b1, 1'b1, 2'b01);
      for (int i = 0; i < 4; i++) begin
         step("R6 hold", 1'b0, i[0], 2'(i));
      end
      step("R6 resume", 1'b1, 1'b1, 2'b00);
   endtask

   task automatic t_idle();
      step("R2 prime", 1'b1, 1'b1, 2'b10);
      step("R2 prime", 1'b1, 1'b1, 2'b11);
      step("R4 idle no strobe", 1'b0, 1'b0, 2'b11);
      step("R5 idle strobe", 1'b1, 1'b0, 2'b11);
      step("R5 idle after", 1'b1, 1'b0, 2'b10);
      chk("R5 state cleared", {1'b0, cs_dly}, 3'b000);
      step("R2 restart", 1'b1, 1'b1, 2'b11);
      step("R2 restart", 1'b1, 1'b1, 2'b01);
      step("R2 restart", 1'b1, 1'b1, 2'b00);
   endtask

   task automatic t_reset_mid();
      step("R2 prime", 1'b1, 1'b1, 2'b11);
      step("R2 prime", 1'b1, 1'b1, 2'b11);
      t_reset();
      step("R1 after reset", 1'b1, 1'b1, 2'b00);
   endtask

   initial begin
      #(CLK_P * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_encode_walk();
      t_hold();
      t_idle();
      t_reset_mid();
      t_encode_walk();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule